// File: doc/BRIEF.md
# Decimal Text Counter Streamer

This block counts lines and sends each count to a host as fixed-width decimal text, one byte per write, over a parallel byte FIFO write port. The count is held directly as a chain of decimal (BCD) digits. The block therefore never converts from binary, and each digit becomes a character with a single add of the ASCII code for '0'.

A line is ten digit characters, most significant first, followed by a newline byte. When a line starts, every digit is copied in one cycle into a line register. The byte at the top of that register drives the data bus, and the register moves up one byte after each write. A write is issued only when the FIFO reports free space. This is signalled on an active-low input. The count steps up by one after every complete line, and it wraps from 4294967295 back to zero.

Top module: `bcd_line_streamer`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `wr_stb` and `line_done` are low. The first line sent carries the value 0.
- R2: A line is NDIG+1 bytes: NDIG digit bytes, each 8'h30 plus the digit value, most significant digit first, then the newline byte 8'h0A.
- R3: `wr_stb` goes high in a cycle only if `space_n` was low at the clock edge that starts that cycle.
- R4: `wr_stb` stays high for exactly one cycle and is then low for at least one cycle.
- R5: `wr_data` in a strobe cycle holds the byte being written, and it is the same value it had in the cycle before.
- R6: Line number k after reset (counting from 0) carries the decimal value k. The count changes only between lines.
- R7: Each digit rolls over from 9 to 0 and carries into the next higher digit.
- R8: After a line carrying MAX_VAL (default 4294967295), the next line carries 0.
- R9: While `space_n` is high, no byte is written. When space returns, the stream continues from the held byte, with nothing lost or repeated.
- R10: `line_done` is high for exactly one cycle: the cycle after the strobe that writes the newline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| space_n | input | 1 | Low when the FIFO can accept a byte |
| wr_stb | output | 1 | Write strobe, one cycle per byte |
| wr_data | output | 8 | Byte being written |
| line_done | output | 1 | One-cycle pulse after a line's newline is written |

## Verification
The stream is driven in three ways:
- With the space input held low, the bench checks the fastest byte and strobe spacing.
- With the space input random per cycle, strobe gating and byte order are exercised at every position in a line.
- With the space input held high for a long stretch in the middle of a line, the bench shows that the byte is held, with no loss or repetition.

A second instance with two digits and a small maximum reaches the 09-to-10 digit carry and the wrap to zero quickly. The default instance covers the carries 9-to-10 and 99-to-100 in the full ten-digit format.

// File: rtl/bcd_stream_pkg.sv
package bcd_stream_pkg;
  localparam int BYTE_W = 8;
  localparam logic [7:0] ASCII_ZERO = 8'h30;
  localparam logic [7:0] NEWLINE = 8'h0A;

  typedef enum logic [1:0] {ST_LOAD, ST_WAIT, ST_STROBE} tx_state_t;

  // decimal digit at position pos (0 = least significant) of v
  function automatic logic [3:0] dec_digit(longint unsigned v, int pos);
    longint unsigned t;
    t = v;
    for (int i = 0; i < pos; i++) t = t / 10;
    return 4'(t % 10);
  endfunction
endpackage

// File: rtl/bcd_counter.sv
module bcd_counter
  import bcd_stream_pkg::*;
#(
  parameter int NDIG = 10,
  parameter longint unsigned MAX_VAL = 64'd4294967295
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  output logic [NDIG*4-1:0] digits
);
  logic [NDIG:0]   carry;
  logic [NDIG-1:0] at_max;
  logic            all_max;

  assign carry[0] = inc;
  assign all_max  = &at_max;

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    localparam logic [3:0] MAXD = dec_digit(MAX_VAL, i);
    logic [3:0] d;
    assign d = digits[i*4 +: 4];
    assign at_max[i] = (d == MAXD);
    assign carry[i+1] = carry[i] && (d == 4'd9);

    always_ff @(posedge clk) begin
      if (rst) begin
        digits[i*4 +: 4] <= '0;
      end else if (inc) begin
        if (all_max)       digits[i*4 +: 4] <= '0;
        else if (carry[i]) digits[i*4 +: 4] <= (d == 4'd9) ? 4'd0 : d + 4'd1;
      end
    end

    // R7: a digit never leaves the decimal range
    p_digit_range_r7: assert property (@(posedge clk) disable iff (rst) d <= 4'd9);
  end

  // R6: count moves only on an increment request
  p_hold_r6: assert property (@(posedge clk) disable iff (rst) !inc |=> $stable(digits));
endmodule

// File: rtl/line_shifter.sv
module line_shifter
  import bcd_stream_pkg::*;
#(
  parameter int NDIG = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              shift,
  input  logic [NDIG*4-1:0] digits,
  output logic [7:0]        byte_out
);
  localparam int LINE_W = (NDIG + 1) * BYTE_W;

  logic [LINE_W-1:0] line_q;
  logic [LINE_W-1:0] line_new;

  // most significant digit lands in the top byte
  for (genvar j = 0; j < NDIG; j++) begin : g_ascii
    assign line_new[LINE_W-1-j*BYTE_W -: BYTE_W] =
      ASCII_ZERO + {4'd0, digits[(NDIG-1-j)*4 +: 4]};
  end
  assign line_new[BYTE_W-1:0] = NEWLINE;

  always_ff @(posedge clk) begin
    if (rst)        line_q <= '0;
    else if (load)  line_q <= line_new;
    else if (shift) line_q <= {line_q[LINE_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
  end

  assign byte_out = line_q[LINE_W-1 -: BYTE_W];
endmodule

// File: rtl/tx_ctrl.sv
module tx_ctrl
  import bcd_stream_pkg::*;
#(
  parameter int NBYTES = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic space_n,
  output logic load,
  output logic shift,
  output logic inc,
  output logic wr_stb,
  output logic line_done
);
  localparam int IDX_W = $clog2(NBYTES);

  tx_state_t        state;
  logic [IDX_W-1:0] idx;
  logic             last;

  assign last  = (idx == IDX_W'(NBYTES - 1));
  assign load  = (state == ST_LOAD);
  assign shift = (state == ST_STROBE);
  assign inc   = shift && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_LOAD;
      idx       <= '0;
      wr_stb    <= 1'b0;
      line_done <= 1'b0;
    end else begin
      line_done <= 1'b0;
      case (state)
        ST_LOAD: begin
          idx   <= '0;
          state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (!space_n) begin
            wr_stb <= 1'b1;
            state  <= ST_STROBE;
          end
        end
        default: begin
          wr_stb <= 1'b0;
          if (last) begin
            line_done <= 1'b1;
            state     <= ST_LOAD;
          end else begin
            idx   <= idx + 1'b1;
            state <= ST_WAIT;
          end
        end
      endcase
    end
  end

  p_stb_needs_space_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_stb) |-> $past(!space_n));
  p_stb_single_r4: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);
  p_done_after_stb_r10: assert property (@(posedge clk) disable iff (rst)
    line_done |-> $past(wr_stb));
  p_idx_range_r2: assert property (@(posedge clk) disable iff (rst)
    idx < IDX_W'(NBYTES));
endmodule

// File: rtl/bcd_line_streamer.sv
module bcd_line_streamer
  import bcd_stream_pkg::*;
#(
  parameter int NDIG = 10,
  parameter longint unsigned MAX_VAL = 64'd4294967295
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       space_n,
  output logic       wr_stb,
  output logic [7:0] wr_data,
  output logic       line_done
);
  localparam int NBYTES = NDIG + 1;

  logic              load, shift, inc;
  logic [NDIG*4-1:0] digits;

  bcd_counter #(.NDIG(NDIG), .MAX_VAL(MAX_VAL)) u_cnt (
    .clk(clk), .rst(rst), .inc(inc), .digits(digits)
  );

  line_shifter #(.NDIG(NDIG)) u_line (
    .clk(clk), .rst(rst), .load(load), .shift(shift),
    .digits(digits), .byte_out(wr_data)
  );

  tx_ctrl #(.NBYTES(NBYTES)) u_ctrl (
    .clk(clk), .rst(rst), .space_n(space_n), .load(load), .shift(shift),
    .inc(inc), .wr_stb(wr_stb), .line_done(line_done)
  );

  // R5: the byte is already on the bus before its strobe
  p_data_stable_r5: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> $stable(wr_data));
endmodule

// File: tb/bcd_line_streamer_tb.sv
`timescale 1ns/1ps
module bcd_line_streamer_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] sp = 2'b11;
  logic       stb0, stb1, dn0, dn1;
  logic [7:0] d0, d1;

  always #2 clk = ~clk;

  bcd_line_streamer u_dut (
    .clk(clk), .rst(rst), .space_n(sp[0]),
    .wr_stb(stb0), .wr_data(d0), .line_done(dn0)
  );

  bcd_line_streamer #(.NDIG(2), .MAX_VAL(64'd42)) u_dut_small (
    .clk(clk), .rst(rst), .space_n(sp[1]),
    .wr_stb(stb1), .wr_data(d1), .line_done(dn1)
  );

  int total = 0, bad = 0;
  int mode = 2;  // 0 random, 1 held full, 2 held free
  int line_no [2];
  int idx [2];
  int bytes_seen [2];
  logic prev_stb [2];
  logic exp_done [2];
  logic [7:0] prev_data [2];
  bit run_mon = 0;

  function automatic logic [7:0] exp_byte(longint unsigned v, int i, int nd);
    longint unsigned t = v;
    if (i == nd) return 8'h0A;
    for (int k = 0; k < nd - 1 - i; k++) t = t / 10;
    return 8'h30 + 8'(t % 10);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic mon(int k, logic stb, logic [7:0] d, logic dn, int nd, longint unsigned mx);
    longint unsigned v;
    string tag;
    chk(dn == exp_done[k], "R10", "line_done", longint'(dn), longint'(exp_done[k]));
    exp_done[k] = 1'b0;
    if (stb) begin
      chk(sp[k] == 1'b0, "R3", "strobe without space", longint'(sp[k]), 0);
      chk(!prev_stb[k], "R4", "strobe back to back", longint'(prev_stb[k]), 0);
      chk(d == prev_data[k], "R5", "data moved at strobe", longint'(d), longint'(prev_data[k]));
      v = longint'(line_no[k]) % (mx + 1);
      if (idx[k] == nd) tag = "R2";
      else if (k == 1) tag = (longint'(line_no[k]) > mx) ? "R8" : "R7";
      else tag = "R6";
      chk(d == exp_byte(v, idx[k], nd), tag, "byte", longint'(d), longint'(exp_byte(v, idx[k], nd)));
      bytes_seen[k]++;
      if (idx[k] == nd) begin
        idx[k] = 0;
        line_no[k]++;
        exp_done[k] = 1'b1;
      end else idx[k]++;
    end
    prev_stb[k] = stb;
    prev_data[k] = d;
  endtask

  // sample and drive away from the rising edge
  always @(negedge clk) begin
    if (run_mon) begin
      mon(0, stb0, d0, dn0, 10, 64'd4294967295);
      mon(1, stb1, d1, dn1, 2, 64'd42);
    end
    for (int k = 0; k < 2; k++) begin
      if (mode == 0)      sp[k] <= (($urandom % 3) == 0);
      else if (mode == 1) sp[k] <= 1'b1;
      else                sp[k] <= 1'b0;
    end
  end

  initial begin
    int unsigned seed_v;
    int b0, b1;
    seed_v = $urandom(32'd2024);
    for (int k = 0; k < 2; k++) begin
      line_no[k] = 0; idx[k] = 0; bytes_seen[k] = 0;
      prev_stb[k] = 0; exp_done[k] = 0; prev_data[k] = 0;
    end
    repeat (4) @(negedge clk);
    // R1: quiet during reset
    chk(stb0 == 0 && dn0 == 0 && stb1 == 0 && dn1 == 0, "R1", "outputs in reset",
        longint'({stb0, dn0, stb1, dn1}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(stb0 == 0 && dn0 == 0 && stb1 == 0 && dn1 == 0, "R1", "outputs after reset",
        longint'({stb0, dn0, stb1, dn1}), 0);
    run_mon = 1;
    repeat (300) @(negedge clk);   // full speed
    mode = 0;
    repeat (1000) @(negedge clk);
    // R9: hold mid-line with no space
    while (idx[0] < 4) @(negedge clk);
    mode = 1;
    @(negedge clk);
    b0 = bytes_seen[0]; b1 = bytes_seen[1];
    repeat (60) @(negedge clk);
    chk(bytes_seen[0] == b0, "R9", "bytes while full", bytes_seen[0], b0);
    chk(bytes_seen[1] == b1, "R9", "bytes while full small", bytes_seen[1], b1);
    mode = 0;
    repeat (4000) @(negedge clk);
    mode = 2;
    repeat (200) @(negedge clk);
    chk(line_no[1] > 44, "R8", "small instance wrapped", line_no[1], 45);
    chk(line_no[0] > 101, "R7", "carry to hundreds reached", line_no[0], 102);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule